// File: doc/BRIEF.md
# UART Control and Status Register Bank

This block holds the software-visible state of a serial port: four control words, a FIFO control word, baud divider words, a one-millisecond tick word and two status words. A host reaches them through a simple word-indexed read/write bus. The receive FIFO, the baud generator and the line logic live elsewhere and connect through flag and strobe pins.

Events from the receive path (ageing timeout, framing error, parity error, overrun, break, character arrival) set sticky status bits. Software clears these bits by writing ones to them. The transmit-idle flags drop when a character is handed over and return when the line side reports completion. Writing the second control word with its bit 0 at zero restores every register to its reset value. A single registered level interrupt combines status bits with their enables.

Top module: `uart_regbank`

## Requirements
- R1: After reset: word 0x20 reads 0x0000, 0x21 reads 0x0001, 0x22 reads 0x0700, 0x23 reads 0x0000, 0x24 reads 0x0801, 0x2A reads 0x0000, 0x2B reads 0x0004, 0x2C reads 0x0000, status word 0x25 reads 0x6040 and status word 0x26 reads 0x4028.
- R2: A write to any control word (0x20–0x24, 0x2A–0x2C) stores only bits 15:0 of the write data, and bits 31:16 read as zero.
- R3: A write to word 0x21 with bit 0 at zero returns every control and status register to its R1 value, except that 0x21 keeps the written value with bit 0 forced to one. Bit 0 of 0x21 always reads one.
- R4: Writing a one clears status bits 15, 10 and 8 of word 0x25 and bits 7, 2 and 1 of word 0x26. Writing a zero leaves them unchanged, and the remaining status bits ignore writes.
- R5: Pulses on age_stb, ferr_stb, perr_stb, ovr_stb and brk_stb set bits 0x25[8], 0x25[10], 0x25[15], 0x26[1] and 0x26[2]. When a pulse and a clearing write fall in the same cycle, the bit ends up set.
- R6: A write to word 0x10 emits tx_stb and tx_char = wdata[7:0] only while 0x21 bit 2 is set. An accepted write clears 0x25[13], 0x26[3] and 0x26[14] until a tx_done pulse. If a new write and tx_done fall in the same cycle, the flags stay cleared.
- R7: A pulse on rx_char_stb sets bit 7 of word 0x26.
- R8: The interrupt is asserted when any of these holds:
  - 0x25[13] and 0x20[13] are both set;
  - 0x25[9] and 0x20[9] are both set;
  - 0x25[8] and 0x21[3] are both set;
  - 0x26[14] and 0x20[6] are both set;
  - 0x26 & 0x23 & 0x008B is nonzero.

  Bit 2 of 0x23 has no effect.
- R9: irq is registered: it reflects the register state one clock after a change.
- R10: Word 0x29, word 0x10 and every unmapped index read zero, and writes to unmapped indices change nothing.
- R11: Reading word 0x00 returns {rx_nonempty, rx_word} in bits 15:0. During that read, rx_pop is high only if rx_nonempty is high.
- R12: Word 0x2D reads bit 6 set while the transmitter is idle and bit 5 set while rx_nonempty is low. All other bits read zero.
- R13: Levels rx_thresh and rx_nonempty appear directly as 0x25[9] and 0x26[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Word index |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data (combinational on addr) |
| tx_stb | output | 1 | Character handed to the transmitter |
| tx_char | output | CHAR_W | Character value |
| tx_done | input | 1 | Transmitter finished the character |
| rx_char_stb | input | 1 | A character arrived |
| rx_thresh | input | 1 | Receive FIFO at or above its threshold |
| rx_nonempty | input | 1 | Receive FIFO holds data |
| rx_word | input | 15 | Head entry of the receive FIFO |
| rx_pop | output | 1 | Receive FIFO pop request |
| age_stb | input | 1 | Receive ageing timeout |
| ferr_stb | input | 1 | Framing error |
| perr_stb | input | 1 | Parity error |
| ovr_stb | input | 1 | Receive overrun |
| brk_stb | input | 1 | Break detected |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can land in the same clock edge. The first pair is a hardware event setting a sticky status bit and a software write clearing that same bit. The second pair is a transmit write and a tx_done pulse. The bench drives each pair on one edge: the event strobe with a write of ones to its status word, and tx_done with a write to the transmit word. In both cases the set side must win: the sticky bit reads one afterwards, and the transmit-idle flags read zero.

// File: rtl/uart_rb_pkg.sv
`timescale 1ns/1ps
package uart_rb_pkg;
  localparam int REG_W   = 16;
  localparam int N_CTRL  = 8;
  localparam int CIDX_W  = $clog2(N_CTRL);

  // word indices
  localparam int A_RXD  = 'h00;
  localparam int A_TXD  = 'h10;
  localparam int A_CR1  = 'h20;
  localparam int A_CR2  = 'h21;
  localparam int A_CR3  = 'h22;
  localparam int A_CR4  = 'h23;
  localparam int A_FCR  = 'h24;
  localparam int A_SR1  = 'h25;
  localparam int A_SR2  = 'h26;
  localparam int A_BINC = 'h29;
  localparam int A_BMOD = 'h2A;
  localparam int A_BCNT = 'h2B;
  localparam int A_MS   = 'h2C;
  localparam int A_TST  = 'h2D;

  // status word 1 bits (ready bits share position with their enables)
  localparam int S1_PERR = 15;
  localparam int S1_RTSS = 14;
  localparam int S1_TRDY = 13;
  localparam int S1_FERR = 10;
  localparam int S1_RRDY = 9;
  localparam int S1_AGE  = 8;
  localparam int S1_RXDS = 6;
  // status word 2 bits (low ones share position with control word 4 enables)
  localparam int S2_TXFE  = 14;
  localparam int S2_WAKE  = 7;
  localparam int S2_DCDIN = 5;
  localparam int S2_TXDC  = 3;
  localparam int S2_BRK   = 2;
  localparam int S2_ORE   = 1;
  localparam int S2_RDR   = 0;
  // control bits
  localparam int C1_TXMPTY = 6;
  localparam int C2_SRST   = 0;
  localparam int C2_TXEN   = 2;
  localparam int C2_ATEN   = 3;
  // test word bits
  localparam int T_TXEMPTY = 6;
  localparam int T_RXEMPTY = 5;

  localparam logic [REG_W-1:0] W1C1_MASK =
    (REG_W'(1) << S1_AGE) | (REG_W'(1) << S1_FERR) | (REG_W'(1) << S1_PERR);
  localparam logic [REG_W-1:0] W1C2_MASK =
    (REG_W'(1) << S2_BRK) | (REG_W'(1) << S2_ORE) | (REG_W'(1) << S2_WAKE);
  localparam logic [REG_W-1:0] C4_IRQ_MASK =
    (REG_W'(1) << S2_WAKE) | (REG_W'(1) << S2_TXDC) |
    (REG_W'(1) << S2_ORE)  | (REG_W'(1) << S2_RDR);
  localparam logic [REG_W-1:0] C1_RDY_MASK =
    (REG_W'(1) << S1_TRDY) | (REG_W'(1) << S1_RRDY);

  typedef enum logic [CIDX_W-1:0] {
    C_CR1, C_CR2, C_CR3, C_CR4, C_FCR, C_BMOD, C_BCNT, C_MS
  } cidx_e;

  typedef struct packed {
    logic              hit;
    logic [CIDX_W-1:0] idx;
  } cdec_t;

  function automatic logic [REG_W-1:0] ctrl_reset(int idx);
    case (idx)
      C_CR2:   return REG_W'(1) << C2_SRST;
      C_CR3:   return REG_W'('h0700);
      C_FCR:   return REG_W'('h0801);
      C_BCNT:  return REG_W'(4);
      default: return '0;
    endcase
  endfunction

  function automatic cdec_t ctrl_decode(int unsigned a);
    cdec_t d;
    d.hit = 1'b1;
    d.idx = '0;
    case (a)
      A_CR1:   d.idx = C_CR1;
      A_CR2:   d.idx = C_CR2;
      A_CR3:   d.idx = C_CR3;
      A_CR4:   d.idx = C_CR4;
      A_FCR:   d.idx = C_FCR;
      A_BMOD:  d.idx = C_BMOD;
      A_BCNT:  d.idx = C_BCNT;
      A_MS:    d.idx = C_MS;
      default: d.hit = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/uart_rb_ctrl.sv
`timescale 1ns/1ps
module uart_rb_ctrl
  import uart_rb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [REG_W-1:0]              wdata,
  input  logic                          soft_rst,
  output logic [N_CTRL-1:0][REG_W-1:0]  cregs_o
);
  cdec_t dec;
  assign dec = ctrl_decode(int'(addr));

  for (genvar g = 0; g < N_CTRL; g++) begin : g_reg
    localparam logic [REG_W-1:0] RV = ctrl_reset(g);
    localparam bit IS_CR2 = (g == int'(C_CR2));
    logic [REG_W-1:0] q, nxt;
    logic             en;

    always_comb begin
      en  = 1'b0;
      nxt = q;
      if (soft_rst) begin
        en  = 1'b1;
        nxt = IS_CR2 ? (wdata | (REG_W'(1) << C2_SRST)) : RV;
      end else if (wr_en && dec.hit && (dec.idx == CIDX_W'(g))) begin
        en  = 1'b1;
        nxt = IS_CR2 ? (wdata | (REG_W'(1) << C2_SRST)) : wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RV;
      else if (en) q <= nxt;
    end

    assign cregs_o[g] = q;
  end
endmodule

// File: rtl/uart_rb_status.sv
`timescale 1ns/1ps
module uart_rb_status
  import uart_rb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             clr1_en,
  input  logic             clr2_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             tx_accept,
  input  logic             tx_done,
  input  logic             age_stb,
  input  logic             ferr_stb,
  input  logic             perr_stb,
  input  logic             ovr_stb,
  input  logic             brk_stb,
  input  logic             rxc_stb,
  input  logic             rx_thresh,
  input  logic             rx_nonempty,
  output logic [REG_W-1:0] usr1_o,
  output logic [REG_W-1:0] usr2_o,
  output logic             tx_busy_o
);
  logic [REG_W-1:0] st1_q, st1_nxt, set1, clr1;
  logic [REG_W-1:0] st2_q, st2_nxt, set2, clr2;
  logic             st1_en, st2_en;
  logic             busy_q, busy_nxt, busy_en;

  always_comb begin
    set1 = '0;
    set1[S1_AGE]  = age_stb;
    set1[S1_FERR] = ferr_stb;
    set1[S1_PERR] = perr_stb;
    set2 = '0;
    set2[S2_ORE]  = ovr_stb;
    set2[S2_BRK]  = brk_stb;
    set2[S2_WAKE] = rxc_stb;
    clr1 = clr1_en ? (wdata & W1C1_MASK) : '0;
    clr2 = clr2_en ? (wdata & W1C2_MASK) : '0;

    st1_en  = soft_rst | clr1_en | (|set1);
    st1_nxt = soft_rst ? '0 : ((st1_q & ~clr1) | set1);
    st2_en  = soft_rst | clr2_en | (|set2);
    st2_nxt = soft_rst ? '0 : ((st2_q & ~clr2) | set2);

    busy_en  = soft_rst | tx_accept | tx_done;
    busy_nxt = soft_rst ? 1'b0 : tx_accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st1_q <= '0;
    else if (st1_en) st1_q <= st1_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st2_q <= '0;
    else if (st2_en) st2_q <= st2_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (busy_en) busy_q <= busy_nxt;
  end

  always_comb begin
    usr1_o          = st1_q;
    usr1_o[S1_TRDY] = !busy_q;
    usr1_o[S1_RRDY] = rx_thresh;
    usr1_o[S1_RXDS] = 1'b1;
    usr1_o[S1_RTSS] = 1'b1;
    usr2_o           = st2_q;
    usr2_o[S2_TXFE]  = !busy_q;
    usr2_o[S2_TXDC]  = !busy_q;
    usr2_o[S2_DCDIN] = 1'b1;
    usr2_o[S2_RDR]   = rx_nonempty;
  end

  assign tx_busy_o = busy_q;
endmodule

// File: rtl/uart_rb_irq.sv
`timescale 1ns/1ps
module uart_rb_irq
  import uart_rb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] usr1,
  input  logic [REG_W-1:0] usr2,
  input  logic [REG_W-1:0] ucr1,
  input  logic [REG_W-1:0] ucr2,
  input  logic [REG_W-1:0] ucr4,
  output logic             irq_o
);
  logic lvl, irq_q;

  always_comb begin
    lvl = (|(usr1 & ucr1 & C1_RDY_MASK))
        | (ucr2[C2_ATEN] & usr1[S1_AGE])
        | (ucr1[C1_TXMPTY] & usr2[S2_TXFE])
        | (|(usr2 & ucr4 & C4_IRQ_MASK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= lvl;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/uart_regbank.sv
`timescale 1ns/1ps
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BUS_W  = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              tx_stb,
  output logic [CHAR_W-1:0] tx_char,
  input  logic              tx_done,
  input  logic              rx_char_stb,
  input  logic              rx_thresh,
  input  logic              rx_nonempty,
  input  logic [REG_W-2:0]  rx_word,
  output logic              rx_pop,
  input  logic              age_stb,
  input  logic              ferr_stb,
  input  logic              perr_stb,
  input  logic              ovr_stb,
  input  logic              brk_stb,
  output logic              irq
);
  logic                         rst_meta, rst_n_s;
  logic [REG_W-1:0]             wd16;
  logic                         unused_wd_hi;
  logic [N_CTRL-1:0][REG_W-1:0] cregs;
  logic [REG_W-1:0]             ucr1, ucr2, ucr4, usr1, usr2;
  logic                         tx_busy, soft_rst, clr1_en, clr2_en;
  logic [REG_W-1:0]             rd16, tst;
  cdec_t                        rdec;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  assign wd16         = wdata[REG_W-1:0];
  assign unused_wd_hi = ^wdata[BUS_W-1:REG_W];

  assign soft_rst = wr_en && (addr == ADDR_W'(A_CR2)) && !wd16[C2_SRST];
  assign clr1_en  = wr_en && (addr == ADDR_W'(A_SR1));
  assign clr2_en  = wr_en && (addr == ADDR_W'(A_SR2));
  assign tx_stb   = wr_en && (addr == ADDR_W'(A_TXD)) && ucr2[C2_TXEN];
  assign tx_char  = wdata[CHAR_W-1:0];
  assign rx_pop   = rd_en && (addr == ADDR_W'(A_RXD)) && rx_nonempty;

  uart_rb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wd16),
    .soft_rst (soft_rst),
    .cregs_o  (cregs)
  );

  assign ucr1 = cregs[C_CR1];
  assign ucr2 = cregs[C_CR2];
  assign ucr4 = cregs[C_CR4];

  uart_rb_status u_status (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .soft_rst    (soft_rst),
    .clr1_en     (clr1_en),
    .clr2_en     (clr2_en),
    .wdata       (wd16),
    .tx_accept   (tx_stb),
    .tx_done     (tx_done),
    .age_stb     (age_stb),
    .ferr_stb    (ferr_stb),
    .perr_stb    (perr_stb),
    .ovr_stb     (ovr_stb),
    .brk_stb     (brk_stb),
    .rxc_stb     (rx_char_stb),
    .rx_thresh   (rx_thresh),
    .rx_nonempty (rx_nonempty),
    .usr1_o      (usr1),
    .usr2_o      (usr2),
    .tx_busy_o   (tx_busy)
  );

  uart_rb_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n_s),
    .usr1  (usr1),
    .usr2  (usr2),
    .ucr1  (ucr1),
    .ucr2  (ucr2),
    .ucr4  (ucr4),
    .irq_o (irq)
  );

  always_comb begin
    tst            = '0;
    tst[T_TXEMPTY] = !tx_busy;
    tst[T_RXEMPTY] = !rx_nonempty;
  end

  assign rdec = ctrl_decode(int'(addr));

  always_comb begin
    rd16 = '0;
    if (rdec.hit) begin
      rd16 = cregs[rdec.idx];
    end else begin
      case (addr)
        ADDR_W'(A_RXD): rd16 = {rx_nonempty, rx_word};
        ADDR_W'(A_SR1): rd16 = usr1;
        ADDR_W'(A_SR2): rd16 = usr2;
        ADDR_W'(A_TST): rd16 = tst;
        default:        rd16 = '0;
      endcase
    end
  end

  assign rdata = BUS_W'(rd16);
endmodule

// File: rtl/uart_regbank_chk.sv
`timescale 1ns/1ps
module uart_regbank_chk #(
  parameter int ADDR_W = 6,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  wdata,
  input logic [BUS_W-1:0]  rdata,
  input logic              tx_stb,
  input logic              rx_char_stb,
  input logic              soft_rst,
  input logic              irq,
  input logic [15:0]       usr1,
  input logic [15:0]       usr2,
  input logic [15:0]       ucr1,
  input logic [15:0]       ucr2,
  input logic [15:0]       ucr4
);
  logic zero_addr;
  assign zero_addr = !((addr == 0) ||
                       (addr >= ADDR_W'('h20) && addr <= ADDR_W'('h26)) ||
                       (addr >= ADDR_W'('h2A) && addr <= ADDR_W'('h2D)));

  a_r3_srst_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    ucr2[0]);

  a_r6_tx_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |-> ucr2[2]);

  a_r6_tx_drops_flags: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |=> (!usr1[13] && !usr2[3] && !usr2[14]));

  a_r7_wake_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_char_stb && !soft_rst) |=> usr2[7]);

  a_r4_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'('h26) && !wdata[7] && usr2[7]) |=> usr2[7]);

  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ucr1 == 16'h0 && !ucr2[3] && ucr4 == 16'h0) |=> !irq);

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && zero_addr) |-> (rdata == '0));
endmodule

bind uart_regbank uart_regbank_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .wdata       (wdata),
  .rdata       (rdata),
  .tx_stb      (tx_stb),
  .rx_char_stb (rx_char_stb),
  .soft_rst    (soft_rst),
  .irq         (irq),
  .usr1        (usr1),
  .usr2        (usr2),
  .ucr1        (ucr1),
  .ucr2        (ucr2),
  .ucr4        (ucr4)
);

// File: tb/uart_regbank_bench.sv
`timescale 1ns/1ps
module uart_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [5:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        tx_stb;
  logic [7:0]  tx_char;
  logic        tx_done, rx_char_stb, rx_thresh, rx_nonempty;
  logic [14:0] rx_word;
  logic        rx_pop;
  logic        age_stb, ferr_stb, perr_stb, ovr_stb, brk_stb;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int tx_count = 0;
  logic [7:0] tx_last = '0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_regbank u_uart_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_stb(tx_stb), .tx_char(tx_char),
    .tx_done(tx_done), .rx_char_stb(rx_char_stb), .rx_thresh(rx_thresh),
    .rx_nonempty(rx_nonempty), .rx_word(rx_word), .rx_pop(rx_pop),
    .age_stb(age_stb), .ferr_stb(ferr_stb), .perr_stb(perr_stb),
    .ovr_stb(ovr_stb), .brk_stb(brk_stb), .irq(irq)
  );

  always @(posedge clk) begin
    if (tx_stb) begin
      tx_count = tx_count + 1;
      tx_last  = tx_char;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d, output logic pop);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    d = rdata; pop = rx_pop;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // strobe index: 0 age, 1 ferr, 2 perr, 3 ovr, 4 brk, 5 rx char
  task automatic set_stb(input int k, input logic v);
    case (k)
      0: age_stb = v;
      1: ferr_stb = v;
      2: perr_stb = v;
      3: ovr_stb = v;
      4: brk_stb = v;
      default: rx_char_stb = v;
    endcase
  endtask

  task automatic pulse(input int k);
    @(negedge clk);
    set_stb(k, 1'b1);
    @(negedge clk);
    set_stb(k, 1'b0);
  endtask

  function automatic logic [15:0] rst_val(input int a);
    case (a)
      'h21: return 16'h0001;
      'h22: return 16'h0700;
      'h24: return 16'h0801;
      'h2B: return 16'h0004;
      'h25: return 16'h6040;
      'h26: return 16'h4028;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [5:0] ctrl_addr(input int i);
    return (i < 5) ? 6'(32 + i) : 6'(42 + i - 5);
  endfunction

  function automatic bit mapped(input int a);
    return (a == 0) || (a == 'h10) || (a >= 'h20 && a <= 'h26) || (a >= 'h2A && a <= 'h2D);
  endfunction

  logic [15:0] exp_c [8];

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        p;
    int          t0;
    int          sa [6];
    int          sb [6];
    rst_n = 0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    tx_done = 0; rx_char_stb = 0; rx_thresh = 0; rx_nonempty = 0; rx_word = '0;
    age_stb = 0; ferr_stb = 0; perr_stb = 0; ovr_stb = 0; brk_stb = 0;
    sa = '{'h25, 'h25, 'h25, 'h26, 'h26, 'h26};
    sb = '{8, 10, 15, 1, 2, 7};
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset values
    for (int i = 0; i < 8; i++) begin
      rd(ctrl_addr(i), d, p);
      chk("R1 ctrl reset", d, {16'h0, rst_val(int'(ctrl_addr(i)))});
    end
    rd(6'h25, d, p); chk("R1 status1 reset", d, 32'h6040);
    rd(6'h26, d, p); chk("R1 status2 reset", d, 32'h4028);
    chk("R8 irq idle after reset", {31'h0, irq}, 32'h0);
    // R12 test word
    rd(6'h2D, d, p); chk("R12 test word idle", d, 32'h0060);

    // R2 write/readback sweep
    for (int i = 0; i < 8; i++) begin
      exp_c[i] = 16'(16'h1111 * (i + 1)) | 16'h0001;
      wr(ctrl_addr(i), {16'hA5A5, exp_c[i]});
    end
    for (int i = 0; i < 8; i++) begin
      rd(ctrl_addr(i), d, p);
      chk("R2 ctrl readback low16", d, {16'h0, exp_c[i]});
    end

    // R10 unmapped sweep
    for (int a = 0; a < 64; a++) begin
      if (!mapped(a)) begin
        wr(6'(a), 32'hFFFF_FFFF);
        rd(6'(a), d, p);
        chk("R10 unmapped reads zero", d, 32'h0);
      end
    end
    rd(6'h10, d, p); chk("R10 transmit word reads zero", d, 32'h0);
    for (int i = 0; i < 8; i++) begin
      rd(ctrl_addr(i), d, p);
      chk("R10 ctrl untouched by unmapped write", d, {16'h0, exp_c[i]});
    end

    // R3 soft reset
    pulse(0); pulse(5);
    wr(6'h21, 32'h0000_0004);
    for (int i = 0; i < 8; i++) begin
      rd(ctrl_addr(i), d, p);
      chk("R3 soft reset ctrl", d,
          (ctrl_addr(i) == 6'h21) ? 32'h0005 : {16'h0, rst_val(int'(ctrl_addr(i)))});
    end
    rd(6'h25, d, p); chk("R3 soft reset status1", d, 32'h6040);
    rd(6'h26, d, p); chk("R3 soft reset status2", d, 32'h4028);

    // R4 / R5 / R7 sticky sweep
    for (int k = 0; k < 6; k++) begin
      logic [15:0] base, bitm;
      base = rst_val(sa[k]);
      bitm = 16'(1) << sb[k];
      pulse(k);
      rd(6'(sa[k]), d, p);
      chk(k == 5 ? "R7 char sets wake" : "R5 event sets bit", d, {16'h0, base | bitm});
      wr(6'(sa[k]), {16'hFFFF, ~bitm});
      rd(6'(sa[k]), d, p);
      chk("R4 zero write keeps bit", d, {16'h0, base | bitm});
      wr(6'(sa[k]), {16'h0, bitm});
      rd(6'(sa[k]), d, p);
      chk("R4 one write clears bit", d, {16'h0, base});
      // collision: event and clearing write on one edge
      @(negedge clk);
      set_stb(k, 1'b1); addr = 6'(sa[k]); wdata = 32'hFFFF; wr_en = 1'b1;
      @(negedge clk);
      set_stb(k, 1'b0); wr_en = 1'b0;
      rd(6'(sa[k]), d, p);
      chk("R5 set wins over clear", d, {16'h0, base | bitm});
      wr(6'(sa[k]), 32'hFFFF);
    end

    // R6 transmit path (TXEN set by the soft reset write)
    t0 = tx_count;
    wr(6'h10, 32'h0000_01C3);
    chk("R6 tx strobe count", 32'(tx_count - t0), 32'd1);
    chk("R6 tx char", {24'h0, tx_last}, 32'hC3);
    rd(6'h25, d, p); chk("R6 busy status1", d, 32'h4040);
    rd(6'h26, d, p); chk("R6 busy status2", d, 32'h0020);
    rd(6'h2D, d, p); chk("R12 test word busy", d, 32'h0020);
    @(negedge clk); tx_done = 1; @(negedge clk); tx_done = 0;
    rd(6'h25, d, p); chk("R6 done status1", d, 32'h6040);
    rd(6'h26, d, p); chk("R6 done status2", d, 32'h4028);
    @(negedge clk);
    addr = 6'h10; wdata = 32'h55; wr_en = 1; tx_done = 1;
    @(negedge clk);
    wr_en = 0; tx_done = 0;
    rd(6'h25, d, p); chk("R6 write wins over done", d, 32'h4040);
    @(negedge clk); tx_done = 1; @(negedge clk); tx_done = 0;
    wr(6'h21, 32'h0001);
    t0 = tx_count;
    wr(6'h10, 32'h0000_0077);
    chk("R6 no strobe without enable", 32'(tx_count - t0), 32'd0);
    rd(6'h25, d, p); chk("R6 flags kept without enable", d, 32'h6040);

    // R11 / R13 receive side
    rx_nonempty = 1; rx_thresh = 1; rx_word = 15'h2ABC;
    rd(6'h00, d, p);
    chk("R11 rx data valid", d, 32'hAABC);
    chk("R11 pop when nonempty", {31'h0, p}, 32'h1);
    rd(6'h25, d, p); chk("R13 threshold flag", d, 32'h6240);
    rd(6'h26, d, p); chk("R13 data ready flag", d, 32'h4029);
    rd(6'h2D, d, p); chk("R12 test word rx data", d, 32'h0040);
    rx_nonempty = 0; rx_thresh = 0;
    rd(6'h00, d, p);
    chk("R11 rx data invalid", d, 32'h2ABC);
    chk("R11 no pop when empty", {31'h0, p}, 32'h0);

    // R9 registered interrupt
    wr(6'h20, 32'h0); wr(6'h23, 32'h0);
    @(negedge clk);
    chk("R9 irq low before", {31'h0, irq}, 32'h0);
    wr(6'h20, 32'h2000);
    chk("R9 irq not yet", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq one clock later", {31'h0, irq}, 32'h1);

    // R8 sweep, state A: idle transmitter, no sticky bits
    wr(6'h25, 32'hFFFF); wr(6'h26, 32'hFFFF);
    for (int c = 0; c < 256; c++) begin
      logic e;
      wr(6'h20, {16'h0, 16'(c[0]) << 13 | 16'(c[1]) << 9 | 16'(c[2]) << 6});
      wr(6'h21, {16'h0, 16'h0005 | 16'(c[3]) << 3});
      wr(6'h23, {16'h0, 16'(c[4]) << 7 | 16'(c[5]) << 3 | 16'(c[6]) << 1 | 16'(c[7])});
      @(negedge clk);
      e = c[0] | c[2] | c[5];
      chk("R8 irq idle sweep", {31'h0, irq}, {31'h0, e});
    end
    // state B: busy transmitter, receive flags and sticky events present
    wr(6'h21, 32'h0005);
    wr(6'h10, 32'h41);
    rx_thresh = 1; rx_nonempty = 1;
    pulse(0); pulse(3); pulse(5); pulse(4);
    for (int c = 0; c < 256; c++) begin
      logic e;
      wr(6'h20, {16'h0, 16'(c[0]) << 13 | 16'(c[1]) << 9 | 16'(c[2]) << 6});
      wr(6'h21, {16'h0, 16'h0005 | 16'(c[3]) << 3});
      wr(6'h23, {16'h0, 16'h0004 | 16'(c[4]) << 7 | 16'(c[5]) << 3 |
                 16'(c[6]) << 1 | 16'(c[7])});
      @(negedge clk);
      e = c[1] | c[3] | c[4] | c[6] | c[7];
      chk("R8 irq busy sweep", {31'h0, irq}, {31'h0, e});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule